// File: doc/BRIEF.md
# NAND Page Read Pointer Controller

This block is the device side of page reads on a byte-wide NAND-style bus. The host writes commands and addresses over an 8-bit data port, using a command-latch strobe, an address-latch strobe and a write-enable pulse. It then clocks data out with read-enable pulses. A read command chooses where a column pointer lands. It can land in the main region of a page (bytes 0..511, from the start or from the second half) or in the 16-byte spare region (bytes 512..527).

After four address cycles (one column byte, then three row bytes, least significant first), the block holds its ready/busy output low for a fixed load time given in clock cycles. After that time, each falling edge of read-enable presents the next byte of the page. Once the last column (527) has been output, the row advances by one and wraps to page 0 after the last page. A new busy wait follows, and streaming resumes at column 0 in main mode or at column 512 in spare mode. Raising chip-enable ends the read.

The flash array is a small synchronous read-only model. The byte at page `p`, column `c` is `(c mod 256) + 16*(c div 256) + 37*p`, taken modulo 256. All inputs are synchronous to `clk`, and strobe edges are detected on the clock.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, `rdy` is 1 and `dout` is 8'h00.
- R2: Command 8'h00 followed by column byte C places the pointer at column C. Successive read-enable falling edges return the array bytes of the latched page at columns C, C+1, ... up to 527.
- R3: Command 8'h01 followed by column byte C places the pointer at column 256+C.
- R4: Command 8'h50 followed by column byte C places the pointer at column 512+C[3:0]. Bits C[7:4] have no effect.
- R5: The rising `we_n` edge that completes the fourth address cycle drives `rdy` low for exactly LOAD_CYCLES clock cycles, after which it returns to 1.
- R6: `dout` changes only in the clock cycle after a read-enable falling edge is detected, and it is otherwise held. Read-enable falling edges while `rdy` is 0 leave `dout` unchanged.
- R7: After column 527 is output, the block goes busy again for LOAD_CYCLES cycles. The next page then continues from column 0 in main mode, or from column 512 (spare bytes only) in spare mode.
- R8: The row address increments on each page rollover and wraps from NUM_PAGES-1 to 0.
- R9: With `ce_n` high, the read ends: `rdy` is 1 from the next cycle, and read-enable edges do not change `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low; high ends a read |
| cle | input | 1 | Command latch strobe, qualifies a write cycle as a command |
| ale | input | 1 | Address latch strobe, qualifies a write cycle as an address byte |
| we_n | input | 1 | Write enable; its rising edge latches `din` |
| re_n | input | 1 | Read enable; its falling edge advances the output byte |
| din | input | 8 | Command or address byte from the host |
| dout | output | 8 | Data byte read from the page |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
Assertions check on every cycle that the column pointer stays within the page and within the spare region in spare mode. They also check that the busy counter never passes the load time, that the output stays stable without a read strobe, that a read strobe never occurs while busy, that the last column forces a busy period and a row increment, and that chip-enable high yields ready on the next cycle. Only the bench scenarios can show the values returned for each pointer command, the exact busy length, the choice of restart column after rollover, wrapping past the last page, and that the high nibble of the spare column is ignored.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    localparam int PAGE_BYTES  = 528;
    localparam int MAIN_BYTES  = 512;
    localparam int HALF_BYTES  = 256;
    localparam int COL_W       = 10;

    localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
    localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);
    localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(HALF_BYTES);

    localparam logic [7:0] CMD_MAIN_LO = 8'h00;
    localparam logic [7:0] CMD_MAIN_HI = 8'h01;
    localparam logic [7:0] CMD_SPARE   = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BUSY,
        ST_STREAM
    } rd_state_e;

    typedef enum logic {
        AREA_MAIN,
        AREA_SPARE
    } rd_area_e;

    typedef struct packed {
        logic we_rise;
        logic re_fall;
    } bus_edges_t;

    // Modelled array contents: a simple arithmetic pattern per page/column.
    function automatic logic [7:0] cell_value(input logic [23:0] page,
                                              input logic [COL_W-1:0] col);
        logic [7:0] hi;
        hi = {2'b00, col[9:8], 4'b0000};
        return col[7:0] + hi + (page[7:0] * 8'd37);
    endfunction

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
    import nand_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we_n,
    input  logic       re_n,
    output bus_edges_t edges
);
    logic we_q;
    logic re_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    always_comb begin
        edges.we_rise = we_n & ~we_q;
        edges.re_fall = re_q & ~re_n;
    end
endmodule

// File: rtl/nand_page_rom.sv
module nand_page_rom
    import nand_rd_pkg::*;
#(
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [7:0]       rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= 8'h00;
        end else if (rd_en) begin
            rd_data <= cell_value(24'(rd_row), rd_col);
        end
    end

    // R6: output holds when no read strobe was issued
    assert_dout_held_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/nand_rd_ctrl.sv
module nand_rd_ctrl
    import nand_rd_pkg::*;
#(
    parameter int ROW_W       = 2,
    parameter int LOAD_CYCLES = 1500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic [7:0]       din,
    input  bus_edges_t       edges,
    output logic             rd_en,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    output logic             ready
);
    localparam int CNT_W = $clog2(LOAD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_CYCLES - 1);

    rd_state_e        state;
    rd_area_e         area;
    logic [COL_W-1:0] col;
    logic [COL_W-1:0] col_base;
    logic [ROW_W-1:0] row;
    logic [1:0]       addr_idx;
    logic [15:0]      row_acc;
    logic [CNT_W-1:0] busy_cnt;
    logic [23:0]      row_full;
    logic             cmd_wr;
    logic             addr_wr;

    assign cmd_wr   = edges.we_rise & cle & ~ce_n;
    assign addr_wr  = edges.we_rise & ale & ~cle & ~ce_n & (state == ST_ADDR);
    assign row_full = {din, row_acc};
    assign rd_en    = (state == ST_STREAM) & edges.re_fall & ~ce_n;
    assign rd_row   = row;
    assign rd_col   = col;
    assign ready    = (state != ST_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            area     <= AREA_MAIN;
            col      <= '0;
            col_base <= '0;
            row      <= '0;
            addr_idx <= '0;
            row_acc  <= '0;
            busy_cnt <= '0;
        end else if (ce_n) begin
            state <= ST_IDLE;
        end else if (cmd_wr) begin
            if (din == CMD_MAIN_LO || din == CMD_MAIN_HI || din == CMD_SPARE) begin
                state    <= ST_ADDR;
                addr_idx <= '0;
                if (din == CMD_SPARE) begin
                    area     <= AREA_SPARE;
                    col_base <= SPARE_BASE;
                end else begin
                    area     <= AREA_MAIN;
                    col_base <= (din == CMD_MAIN_HI) ? HALF_BASE : '0;
                end
            end
        end else if (addr_wr) begin
            addr_idx <= addr_idx + 2'd1;
            case (addr_idx)
                2'd0: begin
                    if (area == AREA_SPARE) col <= SPARE_BASE + {6'd0, din[3:0]};
                    else                    col <= col_base + {2'd0, din};
                end
                2'd1: row_acc[7:0]  <= din;
                2'd2: row_acc[15:8] <= din;
                default: begin
                    row      <= row_full[ROW_W-1:0];
                    state    <= ST_BUSY;
                    busy_cnt <= '0;
                end
            endcase
        end else if (state == ST_BUSY) begin
            if (busy_cnt == CNT_LAST) begin
                state <= ST_STREAM;
            end else begin
                busy_cnt <= busy_cnt + 1'b1;
            end
        end else if (rd_en) begin
            if (col == LAST_COL) begin
                col      <= (area == AREA_SPARE) ? SPARE_BASE : '0;
                row      <= row + 1'b1;
                state    <= ST_BUSY;
                busy_cnt <= '0;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // R2: pointer never leaves the page
    assert_col_in_page_R2: assert property (@(posedge clk) disable iff (rst)
        col <= LAST_COL);
    // R4: spare streaming stays in the spare region
    assert_spare_region_R4: assert property (@(posedge clk) disable iff (rst)
        (area == AREA_SPARE && state == ST_STREAM) |-> col >= SPARE_BASE);
    // R5: busy counter never runs past the load time
    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY) |-> busy_cnt <= CNT_LAST);
    // R7: reading the last column starts a new busy period
    assert_rollover_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && col == LAST_COL) |=> !ready);
    // R8: rollover advances the row by one (wrapping in ROW_W bits)
    assert_row_step_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && col == LAST_COL) |=> row == $past(row) + 1'b1);
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nand_rd_pkg::*;
#(
    parameter int NUM_PAGES   = 4,
    parameter int LOAD_CYCLES = 1500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       rdy
);
    localparam int ROW_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    bus_edges_t       edges;
    logic             rd_en;
    logic [ROW_W-1:0] rd_row;
    logic [COL_W-1:0] rd_col;

    nand_bus_sampler u_sampler (
        .clk   (clk),
        .rst   (rst),
        .we_n  (we_n),
        .re_n  (re_n),
        .edges (edges)
    );

    nand_rd_ctrl #(
        .ROW_W       (ROW_W),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .cle    (cle),
        .ale    (ale),
        .din    (din),
        .edges  (edges),
        .rd_en  (rd_en),
        .rd_row (rd_row),
        .rd_col (rd_col),
        .ready  (rdy)
    );

    nand_page_rom #(
        .ROW_W (ROW_W)
    ) u_rom (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_row  (rd_row),
        .rd_col  (rd_col),
        .rd_data (dout)
    );

    // R9: chip enable high gives ready on the next cycle
    assert_ce_release_R9: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> rdy);
    // R6: no array read is issued while busy
    assert_no_read_busy_R6: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rdy);
endmodule

// File: tb/tb_nand_page_reader.sv
module tb_nand_page_reader;
    localparam int NPG  = 4;
    localparam int LOAD = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1;
    logic       cle = 1'b0;
    logic       ale = 1'b0;
    logic       we_n = 1'b1;
    logic       re_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    nand_page_reader #(.NUM_PAGES(NPG), .LOAD_CYCLES(LOAD)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .din(din), .dout(dout), .rdy(rdy)
    );

    always #4 clk = ~clk;

    function automatic int expect_byte(int page, int c);
        return ((c % 256) + (c / 256) * 16 + page * 37) % 256;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic send_cmd(logic [7:0] b);
        @(negedge clk); cle = 1'b1; din = b; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0;
    endtask

    task automatic send_addr(logic [7:0] b);
        @(negedge clk); ale = 1'b1; din = b; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ale = 1'b0;
    endtask

    task automatic start_read(logic [7:0] cmd, logic [7:0] c, int page);
        send_cmd(cmd);
        send_addr(c);
        send_addr(8'(page));
        send_addr(8'h00);
        send_addr(8'h00);
    endtask

    // Counts busy samples from the current negedge until ready.
    task automatic wait_ready(output int n);
        n = 0;
        while (rdy == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // One read-enable pulse; returns at the negedge after the strobe edge.
    task automatic re_pulse(output int val);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); val = dout; re_n = 1'b1;
    endtask

    initial begin
        int v;
        int n;
        int page;
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdy", rdy, 1);
        check("R1 dout", dout, 0);
        ce_n = 1'b0;

        // R2/R5/R7: main area from column 16 of page 1 to the page end
        start_read(8'h00, 8'h10, 1);
        wait_ready(n);
        check("R5 busy length", n, LOAD);
        for (int k = 16; k < 528; k++) begin
            re_pulse(v);
            check("R2 main byte", v, expect_byte(1, k));
        end
        check("R7 busy after last col", rdy, 0);
        wait_ready(n);
        check("R7 busy length", n, LOAD);
        for (int k = 0; k < 4; k++) begin
            re_pulse(v);
            check("R7 main restart col 0 page 2", v, expect_byte(2, k));
        end
        // R6: output held without strobes
        repeat (5) @(negedge clk);
        check("R6 held", dout, expect_byte(2, 3));

        // R9: end the read while streaming
        ce_n = 1'b1;
        @(negedge clk);
        check("R9 rdy", rdy, 1);
        re_pulse(v);
        check("R9 no output change", v, expect_byte(2, 3));
        ce_n = 1'b0;

        // R3 with a strobe during busy (R6)
        start_read(8'h01, 8'h05, 2);
        check("R5 busy starts", rdy, 0);
        re_pulse(v);
        check("R6 strobe while busy ignored", v, expect_byte(2, 3));
        wait_ready(n);
        for (int k = 0; k < 3; k++) begin
            re_pulse(v);
            check("R3 second half byte", v, expect_byte(2, 261 + k));
        end

        // R4/R7/R8: spare start with ignored high nibble, wrap page 3 -> 0 -> 1
        start_read(8'h50, 8'hF3, 3);
        wait_ready(n);
        check("R5 busy length spare", n, LOAD);
        page = 3;
        c = 515;
        for (int k = 0; k < 13 + 16 + 4; k++) begin
            re_pulse(v);
            check("R4 R8 spare byte", v, expect_byte(page, c));
            if (c == 527) begin
                check("R7 spare busy", rdy, 0);
                wait_ready(n);
                check("R7 spare busy length", n, LOAD);
                page = (page + 1) % NPG;
                c = 512;
            end else begin
                c++;
            end
        end

        // R4: spare column byte 0x07 and 0x37 give the same start
        start_read(8'h50, 8'h37, 0);
        wait_ready(n);
        re_pulse(v);
        check("R4 high nibble ignored", v, expect_byte(0, 519));

        // R8: main rollover from last page wraps to page 0
        start_read(8'h01, 8'hFF, NPG - 1);
        wait_ready(n);
        for (int k = 511; k < 528; k++) begin
            re_pulse(v);
            check("R2 tail byte", v, expect_byte(NPG - 1, k));
        end
        wait_ready(n);
        re_pulse(v);
        check("R8 wrap to page 0", v, expect_byte(0, 0));

        // R9: raising ce_n during busy releases rdy next cycle
        start_read(8'h00, 8'h00, 1);
        ce_n = 1'b1;
        @(negedge clk);
        check("R9 rdy during busy", rdy, 1);
        ce_n = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule